// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers twelve event sources into a sticky 12-bit status register and folds them into one active-high interrupt line. Eleven sources arrive as single-cycle pulses from neighbouring logic. The twelfth comes from a push button as a level, and only its rising edge counts. A source raises the interrupt only while its mask bit is clear.

A host reaches the block through a byte-wide register bus with an address, write data, a write strobe, a read strobe and registered read data. The 12-bit mask, status and acknowledge registers are each split into a low byte (bits 7..0) and a high byte (bits 11..8 in data bits 3..0). Each byte is accessed on its own. Status is read-only and is cleared by writing ones to the acknowledge bytes. Reading never clears a status bit.

Address map (3-bit address): 0 mask low, 1 mask high, 2 status low, 3 status high, 4 acknowledge low, 5 acknowledge high. Addresses 6 and 7 are unused.

Top module: `irq_status_ctrl`

## Requirements
- R1: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0. It updates on the same clock edge as the status or mask change that causes it.
- R2: While `rst` is high and after it falls, the mask is 0xFFF (all sources masked), status is 0, `irq_o` is 0 and `bus_rdata` is 0x00.
- R3: A write to address 0 replaces mask bits 7..0 with `bus_wdata`. A write to address 1 replaces mask bits 11..8 with `bus_wdata[3:0]`. Either write leaves the other half of the mask unchanged.
- R4: A write to address 4 clears each status bit 7..0 whose data bit is 1. A write to address 5 clears each status bit 11..8 whose data bit (3..0) is 1. Status bits written with 0 keep their value.
- R5: A read of address 4 or 5 returns 0x00.
- R6: A read of address 2 returns status bits 7..0, and a read of address 3 returns status bits 11..8 in data bits 3..0. The data appears on `bus_rdata` the cycle after `bus_re`. Reading does not clear status, and writes to addresses 2 and 3 change nothing.
- R7: A one-cycle pulse on `evt_pulse[i]`, for i from 0 to 10, sets status bit i, which stays set until acknowledged. Bit 8 carries the periodic tick, bit 9 the alarm and bit 10 the clock-update error.
- R8: Status bit 11 sets on a 0-to-1 transition of `btn_level`, seen through a two-flop synchronizer (set on the third clock edge after the change). A level that stays high never sets it again.
- R9: When an event sets a bit in the same cycle that an acknowledge write clears it, the bit ends up set.
- R10: Status and mask bits above bit 11 read as 0, writes to them have no effect, and reads of addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 11 | Single-cycle event pulses for status bits 10..0 |
| btn_level | input | 1 | Asynchronous push-button level |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench targets the byte-split mask. If the halves were not independent, a low-byte write would disturb the high mask and `irq_o` would appear or vanish for sources that were never touched. It checks that acknowledge clears only the bits written as ones and that reads leave status alone; a design that cleared on read or cleared whole bytes would lose pending events. A button held high across an acknowledge tests the edge qualification, since a level-triggered design would set bit 11 again at once. An event that coincides with its own acknowledge tests the set-over-clear priority, since the wrong priority drops that event silently.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACK_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACK_HI  = 3'd5;
endpackage

// File: rtl/irq_btn_edge.sv
module irq_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_async,
  output logic btn_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q[g] <= 1'b0;
        end else begin
          if (g == 0) sync_q[g] <= btn_async;
          else        sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign btn_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = NUM_SRC - DATA_W;

  logic [NUM_SRC-1:0] mask_n;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] status_n;

  always_comb begin
    mask_n  = mask_q;
    clr_vec = '0;
    if (we) begin
      unique case (addr)
        A_MASK_LO: mask_n[LO_W-1:0]          = wdata;
        A_MASK_HI: mask_n[NUM_SRC-1:LO_W]    = wdata[HI_W-1:0];
        A_ACK_LO:  clr_vec[LO_W-1:0]         = wdata;
        A_ACK_HI:  clr_vec[NUM_SRC-1:LO_W]   = wdata[HI_W-1:0];
        default: ;
      endcase
    end
    // a fresh event outranks a simultaneous acknowledge
    status_n = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_n;
      status_q <= status_n;
      irq_q    <= |(status_n & ~mask_n);
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               re,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic [DATA_W-1:0]  rdata
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = NUM_SRC - DATA_W;

  logic [DATA_W-1:0] mask_hi_ext;
  logic [DATA_W-1:0] stat_hi_ext;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    mask_hi_ext = '0;
    stat_hi_ext = '0;
    mask_hi_ext[HI_W-1:0] = mask_q[NUM_SRC-1:LO_W];
    stat_hi_ext[HI_W-1:0] = status_q[NUM_SRC-1:LO_W];
    unique case (addr)
      A_MASK_LO: rd_mux = mask_q[LO_W-1:0];
      A_MASK_HI: rd_mux = mask_hi_ext;
      A_STAT_LO: rd_mux = status_q[LO_W-1:0];
      A_STAT_HI: rd_mux = stat_hi_ext;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 12,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-2:0] evt_pulse,
  input  logic               btn_level,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  logic               btn_rise;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;

  irq_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk       (clk),
    .rst       (rst),
    .btn_async (btn_level),
    .btn_rise  (btn_rise)
  );

  assign set_vec = {btn_rise, evt_pulse};

  irq_status_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq_o)
  );

  irq_read_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .re       (bus_re),
    .addr     (bus_addr),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-2:0] evt_pulse,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_we,
  input logic               bus_re,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  localparam int HI_W = NUM_SRC - DATA_W;

  p_irq_match_r1: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & ~mask_q));

  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (mask_q == {NUM_SRC{1'b1}} && status_q == '0 && !irq_o));

  p_mask_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_MASK_LO) |=>
      mask_q[NUM_SRC-1:DATA_W] == $past(mask_q[NUM_SRC-1:DATA_W]));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_ACK_LO && bus_wdata[0] && !evt_pulse[0]) |=> !status_q[0]);

  p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == A_ACK_LO || bus_addr == A_ACK_HI)) |=> bus_rdata == '0);

  p_status_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !(bus_we && bus_addr == A_ACK_LO)) |=> status_q[0]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[0] |=> status_q[0]);

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == A_STAT_HI || bus_addr == A_MASK_HI)) |=>
      bus_rdata[DATA_W-1:HI_W] == '0);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_pulse (evt_pulse),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  import irq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 12;
  localparam int DATA_W     = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-2:0] evt_pulse = '0;
  logic               btn_level = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0]  bus_wdata = '0;
  logic               bus_we = 1'b0;
  logic               bus_re = 1'b0;
  logic [DATA_W-1:0]  bus_rdata;
  logic               irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .btn_level (btn_level),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // monitor: compares registered read data against the queued expectation
  always @(posedge clk) begin
    if (bus_re && !rst) begin
      #2;
      if (exp_q.size() > 0) begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata got %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    bus_re   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC-2:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o got %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk_irq(1'b0, "R2 irq during reset");
    @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R2 irq after reset");
    rd(A_MASK_LO, 8'hFF, "R2 mask low reset");
    rd(A_MASK_HI, 8'h0F, "R2 R10 mask high reset");
    rd(A_STAT_LO, 8'h00, "R2 status low reset");
    rd(A_STAT_HI, 8'h00, "R2 status high reset");

    pulse(11'h001);
    chk_irq(1'b0, "R1 masked event no irq");
    rd(A_STAT_LO, 8'h01, "R7 event bit0 sets");
    wr(A_MASK_LO, 8'hFE);
    chk_irq(1'b1, "R1 unmask raises irq");
    rd(A_MASK_HI, 8'h0F, "R3 high mask untouched");
    rd(A_STAT_LO, 8'h01, "R6 read does not clear");
    rd(A_STAT_LO, 8'h01, "R6 second read");
    rd(A_ACK_LO, 8'h00, "R5 ack low reads zero");
    rd(A_ACK_HI, 8'h00, "R5 ack high reads zero");
    wr(A_STAT_LO, 8'h00);
    rd(A_STAT_LO, 8'h01, "R6 status write ignored");

    wr(A_ACK_LO, 8'hFE);
    rd(A_STAT_LO, 8'h01, "R4 zero bits keep status");
    wr(A_ACK_LO, 8'h01);
    chk_irq(1'b0, "R4 ack drops irq");
    rd(A_STAT_LO, 8'h00, "R4 ack clears bit0");

    pulse(11'h100);
    pulse(11'h600);
    pulse(11'h0A0);
    rd(A_STAT_HI, 8'h07, "R7 tick alarm error bits");
    rd(A_STAT_LO, 8'hA0, "R7 multi-bit event");
    chk_irq(1'b0, "R1 all still masked");
    wr(A_MASK_HI, 8'hFB);
    chk_irq(1'b1, "R1 R3 unmask bit10");
    rd(A_MASK_HI, 8'h0B, "R3 R10 upper mask bits ignored");
    rd(A_MASK_LO, 8'hFE, "R3 low mask untouched");
    wr(A_ACK_HI, 8'h04);
    chk_irq(1'b0, "R4 ack high drops irq");
    rd(A_STAT_HI, 8'h03, "R4 ack high clears bit10 only");
    rd(3'd6, 8'h00, "R10 unused addr 6");
    rd(3'd7, 8'h00, "R10 unused addr 7");

    @(negedge clk);
    btn_level = 1'b1;
    idle(5);
    rd(A_STAT_HI, 8'h0B, "R8 button rise sets bit11");
    wr(A_ACK_HI, 8'h08);
    idle(6);
    rd(A_STAT_HI, 8'h03, "R8 held level no re-set");
    btn_level = 1'b0;
    idle(5);
    btn_level = 1'b1;
    idle(5);
    rd(A_STAT_HI, 8'h0B, "R8 second rise sets bit11");
    wr(A_MASK_HI, 8'h07);
    chk_irq(1'b1, "R1 button unmasked irq");

    wr(A_ACK_LO, 8'hFF);
    wr(A_ACK_HI, 8'hFF);
    rd(A_STAT_LO, 8'h00, "R4 full ack low");
    rd(A_STAT_HI, 8'h00, "R4 full ack high");
    chk_irq(1'b0, "R1 nothing pending");

    @(negedge clk);
    evt_pulse = 11'h001;
    bus_addr  = A_ACK_LO;
    bus_wdata = 8'h01;
    bus_we    = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
    bus_we    = 1'b0;
    chk_irq(1'b1, "R9 set wins raises irq");
    rd(A_STAT_LO, 8'h01, "R9 set wins over ack");

    idle(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule